// File: doc/BRIEF.md
# Volts-per-Hertz Speed Command Chain

This block turns a normalized speed reference and a filtered, normalized rotor-speed measurement into the two set-points that a sine synthesizer needs: a stator frequency command and a stator voltage amplitude command. It works in signed 16-bit fixed point with 1 pu encoded as 0x4000, and it drives a motor in one quadrant only (motoring). All state advances on a single-cycle sample strobe `smp_en`, so the same logic serves any control sample rate.

The reference first passes a first-order soft-start lag, with a coefficient rather than a time constant as its register. The difference between the lagged reference and the measured speed feeds a PI regulator. Its output is a torque request, and the regulator treats that request directly as a slip command. The slip command is held between zero and a programmable torque ceiling. The limited slip is added back to the rotor speed to give the frequency command. The voltage command is a boost offset plus a V/f ratio times frequency, held between zero and 1 pu so that the drive enters field weakening above rated speed. The integrator stops accumulating while the limiter is pushed further into saturation, which prevents wind-up.

The chain is pipelined one stage per strobe. The reference and feedback captured at strobe k reach `freq_cmd` after strobe k+2 and `volt_cmd` after strobe k+3. All arithmetic below uses floor (arithmetic right shift) and states values after the strobe in which they update.

Top module: `vhz_cmd_chain`

## Requirements
- R1: On each strobe the soft-start state F updates as F := F + floor((spd_ref − F)·ss_alpha / 65536), with ss_alpha unsigned. The state never moves past the reference.
- R2: On each strobe the error e = F_prev − fb_prev uses the filter state and the captured feedback from the previous strobe. P = floor(e·kp_gain/4096), where kp_gain is unsigned with 12 fraction bits. The integrator I (24-bit signed, saturating at ±(2^23−1)) adds floor(e·ki_gain/65536), where ki_gain is unsigned with 16 fraction bits. The torque request is S = P + I_prev.
- R3: The slip command equals trq_lim whenever S exceeds trq_lim. trq_lim is a 15-bit unsigned value with 1 pu = 0x4000.
- R4: The slip command is zero whenever S is negative.
- R5: freq_cmd = slip_prev + fb delayed by two strobes, saturated to the range −32768..32767, so it appears one strobe after the slip command.
- R6: volt_cmd = v_off + floor(freq_cmd_prev·vf_gain/32768), where vf_gain is unsigned with 15 fraction bits and v_off is a 15-bit unsigned value. A negative result is replaced by 0.
- R7: volt_cmd never exceeds 0x4000 (1 pu); any larger result is replaced by 0x4000.
- R8: The integrator keeps its value on a strobe where S > trq_lim with e > 0, or where S < 0 with e < 0.
- R9: A synchronous active-high reset clears the filter, the feedback alignment, the integrator and the slip command, and drives freq_cmd and volt_cmd to 0.
- R10: Without a strobe, no state or output changes, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle sample strobe advancing every stage |
| spd_ref | input | 16 | Signed speed reference, 1 pu = 0x4000 |
| spd_fb | input | 16 | Signed filtered rotor speed, 1 pu = 0x4000 |
| ss_alpha | input | 16 | Soft-start coefficient, fraction of 65536 per strobe |
| kp_gain | input | 16 | Proportional gain, 12 fraction bits |
| ki_gain | input | 16 | Integral gain per strobe, 16 fraction bits |
| trq_lim | input | 15 | Torque/slip ceiling, unsigned pu |
| v_off | input | 15 | Voltage boost offset, unsigned pu |
| vf_gain | input | 16 | V/f ratio, 15 fraction bits |
| freq_cmd | output | 16 | Signed stator frequency command |
| volt_cmd | output | 16 | Stator voltage command, 0 to 0x4000 |

## Verification
The embedded properties take for granted that every strobe follows at least one reset edge and that the coefficient inputs describe the same operating point at the strobe as on the cycle before it. Under those conditions, bounds such as the slip ceiling and the reference-approach property of the filter are exact. The stimulus changes references, feedback and gains only on the falling edge between strobes. It leaves an idle cycle after every strobe and never raises the strobe while reset is asserted. It drives the chain into both limiter rails, into frequency saturation, into the 1 pu voltage cap and the zero-voltage floor, through an idle window, and through a reset in the middle of a run.

// File: rtl/vhz_pkg.sv
`timescale 1ns/1ps
package vhz_pkg;
  localparam int unsigned VHZ_DW      = 16;  // data word width
  localparam int unsigned VHZ_CW      = 16;  // coefficient register width
  localparam int unsigned VHZ_IW      = 24;  // integrator width
  localparam int unsigned VHZ_KP_FRAC = 12;
  localparam int unsigned VHZ_KI_FRAC = 16;
  localparam int unsigned VHZ_KV_FRAC = 15;
  localparam int unsigned VHZ_FB_DLY  = 2;   // feedback alignment stages
endpackage

// File: rtl/vhz_align_dly.sv
`timescale 1ns/1ps
module vhz_align_dly #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        en,
  input  logic signed [W-1:0]         d_i,
  output logic [DEPTH-1:0][W-1:0]     tap_o
);
  logic signed [W-1:0] stg_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stg_q[i] <= '0;
    end else if (en) begin
      stg_q[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    assign tap_o[g] = stg_q[g];
  end

  // R10: alignment stages only move on a strobe
  a_r10_dly_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(stg_q[0]));
endmodule

// File: rtl/vhz_softstart.sv
`timescale 1ns/1ps
module vhz_softstart #(
  parameter int W  = 16,
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [W-1:0]  ref_i,
  input  logic [CW-1:0]        alpha_i,
  output logic signed [W-1:0]  filt_o
);
  localparam int DW = W + 1;
  localparam int PW = DW + CW + 1;

  logic signed [W-1:0]  filt_q;
  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] diff_p, alpha_p, prod, step;
  logic signed [DW-1:0] nxt;
  logic                 unused_step;

  always_comb begin
    diff    = {ref_i[W-1], ref_i} - {filt_q[W-1], filt_q};
    diff_p  = {{(PW-DW){diff[DW-1]}}, diff};
    alpha_p = {{(PW-CW){1'b0}}, alpha_i};
    prod    = diff_p * alpha_p;
    step    = prod >>> CW;
    nxt     = {filt_q[W-1], filt_q} + step[DW-1:0];
  end

  assign unused_step = ^step[PW-1:DW];

  always_ff @(posedge clk) begin
    if (rst)      filt_q <= '0;
    else if (en)  filt_q <= nxt[W-1:0];
  end

  assign filt_o = filt_q;

  // R1: a step moves toward the reference and never past it
  a_r1_no_overshoot: assert property (@(posedge clk) disable iff (rst)
    en && (ref_i >= filt_q) |=> (filt_q >= $past(filt_q)) && (filt_q <= $past(ref_i)));
  // R10: the lag state holds between strobes
  a_r10_filt_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(filt_q));
endmodule

// File: rtl/vhz_pi_limit.sv
`timescale 1ns/1ps
module vhz_pi_limit #(
  parameter int W       = 16,
  parameter int CW      = 16,
  parameter int IW      = 24,
  parameter int KP_FRAC = 12,
  parameter int KI_FRAC = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [W-1:0]  cmd_i,
  input  logic signed [W-1:0]  fb_i,
  input  logic [CW-1:0]        kp_i,
  input  logic [CW-1:0]        ki_i,
  input  logic [W-2:0]         lim_i,
  output logic signed [W-1:0]  slip_o
);
  localparam int EW = W + 1;
  localparam int AW = EW + CW + 2;
  localparam logic signed [AW-1:0] IMAX_A = {{(AW-IW+1){1'b0}}, {(IW-1){1'b1}}};
  localparam logic signed [AW-1:0] IMIN_A = -IMAX_A;

  logic signed [IW-1:0] integ_q;
  logic signed [W-1:0]  slip_q;
  logic signed [EW-1:0] err;
  logic signed [AW-1:0] e_a, kp_a, ki_a, p_a, i_a, integ_a, sum_a, lim_a, acc_a, sat_a;
  logic                 hi, lo, e_pos, e_neg, freeze;
  logic signed [W-1:0]  slip_n;

  always_comb begin
    err     = {cmd_i[W-1], cmd_i} - {fb_i[W-1], fb_i};
    e_a     = {{(AW-EW){err[EW-1]}}, err};
    kp_a    = {{(AW-CW){1'b0}}, kp_i};
    ki_a    = {{(AW-CW){1'b0}}, ki_i};
    p_a     = (e_a * kp_a) >>> KP_FRAC;
    i_a     = (e_a * ki_a) >>> KI_FRAC;
    integ_a = {{(AW-IW){integ_q[IW-1]}}, integ_q};
    sum_a   = p_a + integ_a;
    lim_a   = {{(AW-W+1){1'b0}}, lim_i};
    hi      = sum_a > lim_a;
    lo      = sum_a[AW-1];
    e_neg   = err[EW-1];
    e_pos   = !err[EW-1] && (err != '0);
    freeze  = (hi && e_pos) || (lo && e_neg);
    acc_a   = integ_a + i_a;
    if (acc_a > IMAX_A)      sat_a = IMAX_A;
    else if (acc_a < IMIN_A) sat_a = IMIN_A;
    else                     sat_a = acc_a;
    if (hi)      slip_n = lim_a[W-1:0];
    else if (lo) slip_n = '0;
    else         slip_n = sum_a[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      integ_q <= '0;
      slip_q  <= '0;
    end else if (en) begin
      slip_q <= slip_n;
      if (!freeze) integ_q <= sat_a[IW-1:0];
    end
  end

  assign slip_o = slip_q;

  // R3: slip never exceeds the ceiling presented at the strobe
  a_r3_slip_ceiling: assert property (@(posedge clk) disable iff (rst)
    en |=> $unsigned(slip_q) <= {1'b0, $past(lim_i)});
  // R4: negative error with a non-positive integrator gives zero slip
  a_r4_slip_floor: assert property (@(posedge clk) disable iff (rst)
    en && (cmd_i < fb_i) && (integ_q <= 0) |=> slip_q == '0);
  // R8: integration pauses while pushing further into the upper rail
  a_r8_freeze_hi: assert property (@(posedge clk) disable iff (rst)
    en && e_pos && hi |=> $stable(integ_q));
  // R2: zero error leaves the integrator unchanged
  a_r2_zero_err: assert property (@(posedge clk) disable iff (rst)
    en && (cmd_i == fb_i) |=> $stable(integ_q));
endmodule

// File: rtl/vhz_volt_law.sv
`timescale 1ns/1ps
module vhz_volt_law #(
  parameter int W       = 16,
  parameter int CW      = 16,
  parameter int KV_FRAC = 15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [W-1:0]  slip_i,
  input  logic signed [W-1:0]  fb_i,
  input  logic [W-2:0]         off_i,
  input  logic [CW-1:0]        kv_i,
  output logic signed [W-1:0]  freq_o,
  output logic signed [W-1:0]  volt_o
);
  localparam int SW = W + 1;
  localparam int VW = W + CW + 2;
  localparam logic signed [W-1:0] ONE_PU = {2'b01, {(W-2){1'b0}}};
  localparam logic signed [W-1:0] MAXP   = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINN   = {1'b1, {(W-1){1'b0}}};

  logic signed [W-1:0]  freq_q, volt_q, freq_n, volt_n;
  logic signed [SW-1:0] fsum;
  logic signed [VW-1:0] f_v, kv_v, vp, vs, one_v;

  always_comb begin
    fsum = {slip_i[W-1], slip_i} + {fb_i[W-1], fb_i};
    if (fsum[SW-1] != fsum[SW-2]) freq_n = fsum[SW-1] ? MINN : MAXP;
    else                          freq_n = fsum[W-1:0];
    f_v   = {{(VW-W){freq_q[W-1]}}, freq_q};
    kv_v  = {{(VW-CW){1'b0}}, kv_i};
    vp    = (f_v * kv_v) >>> KV_FRAC;
    vs    = vp + {{(VW-W+1){1'b0}}, off_i};
    one_v = {{(VW-W){1'b0}}, ONE_PU};
    if (vs[VW-1])      volt_n = '0;
    else if (vs > one_v) volt_n = ONE_PU;
    else               volt_n = vs[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_q <= '0;
      volt_q <= '0;
    end else if (en) begin
      freq_q <= freq_n;
      volt_q <= volt_n;
    end
  end

  assign freq_o = freq_q;
  assign volt_o = volt_q;

  // R5: with no slip the frequency command is the aligned rotor speed
  a_r5_zero_slip: assert property (@(posedge clk) disable iff (rst)
    en && (slip_i == '0) |=> freq_q == $past(fb_i));
  // R7: the voltage command stays within 0..1 pu
  a_r7_volt_cap: assert property (@(posedge clk) disable iff (rst)
    en |=> (volt_q <= ONE_PU) && (volt_q >= 0));
  // R10: both commands hold between strobes
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(freq_q) && $stable(volt_q));
  // R9: reset clears both commands
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (freq_q == '0) && (volt_q == '0));
endmodule

// File: rtl/vhz_cmd_chain.sv
`timescale 1ns/1ps
module vhz_cmd_chain
  import vhz_pkg::*;
#(
  parameter int W       = VHZ_DW,
  parameter int CW      = VHZ_CW,
  parameter int IW      = VHZ_IW,
  parameter int KP_FRAC = VHZ_KP_FRAC,
  parameter int KI_FRAC = VHZ_KI_FRAC,
  parameter int KV_FRAC = VHZ_KV_FRAC
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_en,
  input  logic signed [W-1:0]  spd_ref,
  input  logic signed [W-1:0]  spd_fb,
  input  logic [CW-1:0]        ss_alpha,
  input  logic [CW-1:0]        kp_gain,
  input  logic [CW-1:0]        ki_gain,
  input  logic [W-2:0]         trq_lim,
  input  logic [W-2:0]         v_off,
  input  logic [CW-1:0]        vf_gain,
  output logic signed [W-1:0]  freq_cmd,
  output logic signed [W-1:0]  volt_cmd
);
  localparam int FB_DLY = VHZ_FB_DLY;

  logic signed [W-1:0]        filt, slip, fb_s1, fb_s2;
  logic [FB_DLY-1:0][W-1:0]   fb_taps;

  vhz_softstart #(.W(W), .CW(CW)) u_soft (
    .clk(clk), .rst(rst), .en(smp_en),
    .ref_i(spd_ref), .alpha_i(ss_alpha), .filt_o(filt));

  vhz_align_dly #(.W(W), .DEPTH(FB_DLY)) u_fbdly (
    .clk(clk), .rst(rst), .en(smp_en),
    .d_i(spd_fb), .tap_o(fb_taps));

  assign fb_s1 = $signed(fb_taps[0]);
  assign fb_s2 = $signed(fb_taps[FB_DLY-1]);

  vhz_pi_limit #(.W(W), .CW(CW), .IW(IW), .KP_FRAC(KP_FRAC), .KI_FRAC(KI_FRAC)) u_pi (
    .clk(clk), .rst(rst), .en(smp_en),
    .cmd_i(filt), .fb_i(fb_s1), .kp_i(kp_gain), .ki_i(ki_gain),
    .lim_i(trq_lim), .slip_o(slip));

  vhz_volt_law #(.W(W), .CW(CW), .KV_FRAC(KV_FRAC)) u_volt (
    .clk(clk), .rst(rst), .en(smp_en),
    .slip_i(slip), .fb_i(fb_s2), .off_i(v_off), .kv_i(vf_gain),
    .freq_o(freq_cmd), .volt_o(volt_cmd));
endmodule

// File: tb/vhz_cmd_chain_tb.sv
`timescale 1ns/1ps
module vhz_cmd_chain_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic signed [15:0] spd_ref = '0, spd_fb = '0;
  logic [15:0] ss_alpha = '0, kp_gain = '0, ki_gain = '0, vf_gain = '0;
  logic [14:0] trq_lim = '0, v_off = '0;
  logic signed [15:0] freq_cmd, volt_cmd;

  vhz_cmd_chain dut_i (
    .clk(clk), .rst(rst), .smp_en(smp_en), .spd_ref(spd_ref), .spd_fb(spd_fb),
    .ss_alpha(ss_alpha), .kp_gain(kp_gain), .ki_gain(ki_gain), .trq_lim(trq_lim),
    .v_off(v_off), .vf_gain(vf_gain), .freq_cmd(freq_cmd), .volt_cmd(volt_cmd));

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  typedef struct { longint f; longint v; string tag; } exp_t;
  exp_t sb_q[$];
  longint m_filt, m_fb1, m_fb2, m_integ, m_slip, m_freq, m_volt;

  task automatic check_val(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic model_clear();
    m_filt = 0; m_fb1 = 0; m_fb2 = 0; m_integ = 0; m_slip = 0; m_freq = 0; m_volt = 0;
  endtask

  // Reference model written from R1..R8
  task automatic model_step(string tag);
    longint e, p, s, inc, nf, ni, ns, nq, nv, lim, imax;
    exp_t it;
    imax = (64'sd1 <<< 23) - 1;
    lim  = longint'(trq_lim);
    nf = m_filt + (((longint'(spd_ref) - m_filt) * longint'(ss_alpha)) >>> 16);   // R1
    e  = m_filt - m_fb1;                                                          // R2
    p  = (e * longint'(kp_gain)) >>> 12;
    s  = p + m_integ;
    if (s > lim) ns = lim; else if (s < 0) ns = 0; else ns = s;                  // R3, R4
    inc = (e * longint'(ki_gain)) >>> 16;
    if ((s > lim && e > 0) || (s < 0 && e < 0)) ni = m_integ;                     // R8
    else begin
      ni = m_integ + inc;
      if (ni > imax) ni = imax;
      if (ni < -imax) ni = -imax;
    end
    nq = m_slip + m_fb2;                                                          // R5
    if (nq > 32767) nq = 32767;
    if (nq < -32768) nq = -32768;
    nv = longint'(v_off) + ((m_freq * longint'(vf_gain)) >>> 15);                 // R6
    if (nv < 0) nv = 0;
    if (nv > 16384) nv = 16384;                                                   // R7
    m_fb2 = m_fb1; m_fb1 = longint'(spd_fb);
    m_filt = nf; m_integ = ni; m_slip = ns; m_freq = nq; m_volt = nv;
    it.f = nq; it.v = nv; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Driver: raise the strobe on a falling edge and push the expectation
  task automatic strobe(string tag);
    @(negedge clk);
    smp_en = 1'b1;
    model_step(tag);
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) strobe(tag);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_val("R9", "freq_rst", longint'(freq_cmd), 0);
    check_val("R9", "volt_rst", longint'(volt_cmd), 0);
    rst = 1'b0;
    model_clear();
  endtask

  // Monitor: compare right after each strobe edge
  initial begin
    forever begin
      @(posedge clk);
      if (smp_en && !rst) begin
        #1;
        if (sb_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10 scoreboard_empty act=0 exp=1");
        end else begin
          exp_t it;
          it = sb_q.pop_front();
          check_val(it.tag, "freq", longint'(freq_cmd), it.f);
          check_val(it.tag, "volt", longint'(volt_cmd), it.v);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R10 watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    longint hf, hv;
    model_clear();
    apply_reset();

    // R1, R2, R3, R8: large step drives the slip into its ceiling
    ss_alpha = 16'h2000; kp_gain = 16'h1000; ki_gain = 16'h0400;
    trq_lim = 15'h2000; v_off = 15'h0100; vf_gain = 16'h7800;
    spd_ref = 16'sh4000; spd_fb = 16'sh0000;
    run(30, "R3+R8");
    // R2: rotor catches up, error shrinks
    spd_fb = 16'sh3000;
    run(20, "R2");
    // R4: rotor above reference, slip driven to zero
    spd_fb = 16'sh4800;
    run(30, "R4");
    // R5, R7: high speed, frequency saturation and voltage cap
    trq_lim = 15'h7FFF; spd_ref = 16'sh7FFF; spd_fb = 16'sh7000;
    run(15, "R5+R7");
    // R6: small operating point, affine voltage law
    trq_lim = 15'h1000; vf_gain = 16'h7333; v_off = 15'h0080;
    spd_ref = 16'sh0800; spd_fb = 16'sh0700;
    run(25, "R6");
    // R6: negative rotor speed drives the voltage to its floor
    spd_ref = -16'sh3000; spd_fb = -16'sh2000;
    run(30, "R6+R4");

    // R10: inputs move with no strobe, outputs must hold
    @(negedge clk);
    hf = longint'(freq_cmd); hv = longint'(volt_cmd);
    spd_ref = 16'sh7000; spd_fb = 16'sh0100; kp_gain = 16'hFFFF; v_off = 15'h7FFF;
    repeat (6) @(negedge clk);
    check_val("R10", "freq_hold", longint'(freq_cmd), hf);
    check_val("R10", "volt_hold", longint'(volt_cmd), hv);
    kp_gain = 16'h1000; v_off = 15'h0080;
    run(10, "R10");

    // R9: reset in the middle of a run, then restart
    apply_reset();
    // R8: narrow ceiling, long saturation, then recovery
    trq_lim = 15'h0800; ss_alpha = 16'h4000; ki_gain = 16'h1000;
    spd_ref = 16'sh3000; spd_fb = 16'sh0000;
    run(40, "R8");
    spd_fb = 16'sh2FF0;
    run(20, "R8");

    repeat (4) @(negedge clk);
    check_val("R1", "sb_drained", longint'(sb_q.size()), 0);
    finish_run();
  end
endmodule